// File: doc/BRIEF.md
# Flash Command Front End with Query Mode

This block is the host-side command logic of a parallel NOR-style flash device. It sits on a 16-bit, word-addressed asynchronous bus with active-low chip enable, write enable and output enable. A sampling clock registers the bus pins. The block checks each bus cycle to decide whether it is a valid write. A valid write is latched when write enable rises, and it can change the mode. The mode is read-array, autoselect (identifier) or query. In query mode a small table of identification words is returned.

A lockout input stands for a low supply. While it is high, the mode is forced back to read-array and every write is discarded. After power-on reset the block will not accept a write cycle that was already in progress when reset ended. In read-array mode the word comes from an external array through a plain combinational read port.

Top module: `flash_cmd_if`

## Requirements
- R1: A write cycle counts only while chip enable is low, write enable is low and output enable is high. Output enable low or chip enable high during the low phase of write enable means the following rise of write enable has no effect.
- R2: The command uses the address and data present in the last sampled cycle before write enable rises. The mode changes only after that rise.
- R3: From read-array mode, writing data 0098h to word address 055h enters query mode.
- R4: From autoselect mode, writing 0098h to address 055h also enters query mode.
- R5: Query mode is left only by the reset command, data 00F0h at any address, which returns to read-array. A write of 0090h to 555h in query mode is ignored.
- R6: In query mode these word addresses return these values: 10h→0051h, 11h→0052h, 12h→0059h, 13h→0002h, 14h→0000h, 15h→0040h, 16h→0000h, and 17h to 1Ah→0000h.
- R7: In query mode any address not listed in R6 returns 0000h.
- R8: While lockout is high the mode is forced to read-array and writes are ignored. Writes are accepted again once lockout is low.
- R9: Reset sets the mode to read-array. A write whose low phase began before reset ended is not accepted on the next rise of write enable.
- R10: Writing 0090h to address 555h from read-array mode enters autoselect. In autoselect, address 0 returns the manufacturer code (default 0001h), address 1 returns the device code (default 227Eh), and other addresses return 0000h.
- R11: `dq_oe` is high only when chip enable and output enable were both low in the cycle sampled two clocks earlier. While `dq_oe` is low, `dq_out` is 0000h.
- R12: In read-array mode the read data is `array_rdata` for `array_addr`, and `array_addr` carries the sampled bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| lockout | input | 1 | Low-supply lockout, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from host |
| dq_out | output | 16 | Read data to host |
| dq_oe | output | 1 | Data bus drive enable; bus is released when low |
| array_addr | output | ADDR_W | Array read address |
| array_rdata | input | 16 | Array read data |

## Verification
The assertions assume that the bus pins change no faster than the sampling clock. They also assume each write low phase lasts at least two clock cycles, so the registered sample sees it. The bench changes the pins only on falling clock edges. It holds each phase of a write or read for two to three cycles and samples outputs three edges after driving. Lockout is changed only while the bus is idle, so the checks never depend on a write cycle that overlaps a lockout edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_QUERY   = 2'd2
    } mode_e;

    localparam logic [15:0] CMD_RESET   = 16'h00F0;
    localparam logic [15:0] CMD_QUERY   = 16'h0098;
    localparam logic [15:0] CMD_AUTOSEL = 16'h0090;
    localparam int unsigned QUERY_ADDR   = 'h55;
    localparam int unsigned AUTOSEL_ADDR = 'h555;
endpackage

// File: rtl/flash_bus_qual.sv
module flash_bus_qual (
    input  logic s_ce_n,
    input  logic s_we_n,
    input  logic s_oe_n,
    input  logic s_lock,
    input  logic armed_q,
    input  logic qual_q,
    output logic qual_d,
    output logic armed_d,
    output logic wr_evt,
    output logic rd_en
);
    always_comb begin
        armed_d = armed_q | s_we_n;
        qual_d  = !s_ce_n && !s_we_n && s_oe_n && armed_q && !s_lock;
        wr_evt  = qual_q && s_we_n && !s_lock;
        rd_en   = !s_ce_n && !s_oe_n;
    end
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  mode_e              mode_q,
    input  logic               wr_evt,
    input  logic               s_lock,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [15:0]        cmd_data,
    output mode_e              mode_d
);
    localparam logic [ADDR_W-1:0] QADDR = ADDR_W'(QUERY_ADDR);
    localparam logic [ADDR_W-1:0] AADDR = ADDR_W'(AUTOSEL_ADDR);

    always_comb begin
        mode_d = mode_q;
        if (s_lock) begin
            mode_d = MODE_READ;
        end else if (wr_evt) begin
            if (cmd_data == CMD_RESET) begin
                mode_d = MODE_READ;
            end else if (cmd_data == CMD_QUERY && cmd_addr == QADDR &&
                         (mode_q == MODE_READ || mode_q == MODE_AUTOSEL)) begin
                mode_d = MODE_QUERY;
            end else if (cmd_data == CMD_AUTOSEL && cmd_addr == AADDR &&
                         mode_q == MODE_READ) begin
                mode_d = MODE_AUTOSEL;
            end
        end
    end
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W = 23,
    parameter logic [15:0] MFR_ID = 16'h0001,
    parameter logic [15:0] DEV_ID = 16'h227E
) (
    input  mode_e              mode_q,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [15:0]        array_rdata,
    output logic [15:0]        rd_word
);
    function automatic logic [15:0] query_word(input logic [ADDR_W-1:0] a);
        logic [15:0] w;
        w = 16'h0000;
        case (a)
            ADDR_W'('h10): w = 16'h0051;
            ADDR_W'('h11): w = 16'h0052;
            ADDR_W'('h12): w = 16'h0059;
            ADDR_W'('h13): w = 16'h0002;
            ADDR_W'('h15): w = 16'h0040;
            default:       w = 16'h0000;
        endcase
        return w;
    endfunction

    always_comb begin
        unique case (mode_q)
            MODE_AUTOSEL: begin
                if (rd_addr == '0)
                    rd_word = MFR_ID;
                else if (rd_addr == ADDR_W'(1))
                    rd_word = DEV_ID;
                else
                    rd_word = 16'h0000;
            end
            MODE_QUERY: rd_word = query_word(rd_addr);
            default:    rd_word = array_rdata;
        endcase
    end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W = 23,
    parameter logic [15:0] MFR_ID = 16'h0001,
    parameter logic [15:0] DEV_ID = 16'h227E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lockout,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] array_addr,
    input  logic [15:0]       array_rdata
);
    typedef struct packed {
        mode_e              mode;
        logic               s_ce_n;
        logic               s_we_n;
        logic               s_oe_n;
        logic               s_lock;
        logic [ADDR_W-1:0]  s_addr;
        logic [15:0]        s_data;
        logic               armed;
        logic               qual;
        logic [ADDR_W-1:0]  cmd_addr;
        logic [15:0]        cmd_data;
        logic               oe;
        logic [15:0]        dout;
    } state_t;

    state_t st_d, st_q;

    logic  qual_d, armed_d, wr_evt, rd_en;
    mode_e mode_d;
    logic [15:0] rd_word;

    flash_bus_qual u_qual (
        .s_ce_n (st_q.s_ce_n),
        .s_we_n (st_q.s_we_n),
        .s_oe_n (st_q.s_oe_n),
        .s_lock (st_q.s_lock),
        .armed_q(st_q.armed),
        .qual_q (st_q.qual),
        .qual_d (qual_d),
        .armed_d(armed_d),
        .wr_evt (wr_evt),
        .rd_en  (rd_en)
    );

    flash_mode_ctl #(.ADDR_W(ADDR_W)) u_mode (
        .mode_q  (st_q.mode),
        .wr_evt  (wr_evt),
        .s_lock  (st_q.s_lock),
        .cmd_addr(st_q.cmd_addr),
        .cmd_data(st_q.cmd_data),
        .mode_d  (mode_d)
    );

    flash_id_rom #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rom (
        .mode_q     (st_q.mode),
        .rd_addr    (st_q.s_addr),
        .array_rdata(array_rdata),
        .rd_word    (rd_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s_ce_n = ce_n;
        st_d.s_we_n = we_n;
        st_d.s_oe_n = oe_n;
        st_d.s_lock = lockout;
        st_d.s_addr = addr;
        st_d.s_data = dq_in;
        st_d.armed  = armed_d;
        st_d.qual   = qual_d;
        if (qual_d) begin
            st_d.cmd_addr = st_q.s_addr;
            st_d.cmd_data = st_q.s_data;
        end
        st_d.mode = mode_d;
        st_d.oe   = rd_en;
        st_d.dout = rd_en ? rd_word : 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mode   <= MODE_READ;
            st_q.s_ce_n <= 1'b1;
            st_q.s_oe_n <= 1'b1;
            st_q.s_we_n <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out     = st_q.dout;
    assign dq_oe      = st_q.oe;
    assign array_addr = st_q.s_addr;

    logic [1:0] mode_obs;
    logic       lock_obs;
    assign mode_obs = st_q.mode;
    assign lock_obs = st_q.s_lock;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       dq_oe,
    input logic [1:0] mode,
    input logic       lock_s,
    input logic       wr_evt
);
    localparam logic [1:0] M_READ  = 2'd0;
    localparam logic [1:0] M_QUERY = 2'd2;

    p_lock_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_s |=> (mode == M_READ))
        else $error("lockout did not force read-array");

    p_query_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_QUERY) |=> (mode == M_QUERY || mode == M_READ))
        else $error("query left to a mode other than read-array");

    p_mode_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $past(wr_evt || lock_s))
        else $error("mode changed without a write event or lockout");

    p_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!ce_n && !oe_n, 2))
        else $error("bus driven without chip and output enable");
endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .dq_oe (dq_oe),
    .mode  (mode_obs),
    .lock_s(lock_obs),
    .wr_evt(wr_evt)
);

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
    localparam int AW = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lockout = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic dq_oe;
    logic [AW-1:0] array_addr;
    logic [15:0] array_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign array_rdata = array_addr[15:0] ^ 16'h5A3C;

    flash_cmd_if uut (
        .clk(clk), .rst_n(rst_n), .lockout(lockout),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .array_addr(array_addr), .array_rdata(array_rdata)
    );

    typedef struct {
        logic        oe;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t sb[$];
    event smp;

    function automatic logic [15:0] arr(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    always begin
        @(smp);
        if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL monitor: sample with empty queue");
        end else begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (dq_oe !== e.oe || dq_out !== e.data) begin
                errors++;
                $display("FAIL %s: got oe=%b data=%h expected oe=%b data=%h",
                         e.tag, dq_oe, dq_out, e.oe, e.data);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic c_n, input logic o_n,
                            input logic [15:0] exp_d, input string tag);
        exp_t e;
        @(negedge clk);
        ce_n = c_n; oe_n = o_n; we_n = 1'b1; addr = a;
        e.oe = !c_n && !o_n;
        e.data = e.oe ? exp_d : 16'h0000;
        e.tag = tag;
        sb.push_back(e);
        idle(3);
        -> smp;
        #1;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(1);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d,
                             input logic c_n, input logic o_n);
        @(negedge clk);
        ce_n = c_n; oe_n = o_n; we_n = 1'b0; addr = a; dq_in = d;
        idle(3);
        we_n = 1'b1;
        idle(2);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t e;
        // R9: power-up with a write low phase already in progress
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 'h55; dq_in = 16'h0098;
        idle(4);
        rst_n = 1'b1;
        idle(3);
        // reset state: bus released
        e.oe = 1'b0; e.data = 16'h0000; e.tag = "R9 reset state"; sb.push_back(e);
        -> smp; #1;
        we_n = 1'b1;
        idle(3);
        ce_n = 1'b1;
        idle(2);
        bus_read('h10, 1'b0, 1'b0, arr('h10), "R9 power-up write inhibited");

        // R12 read array, R11 drive enable
        bus_read('h123, 1'b0, 1'b0, arr('h123), "R12 array read");
        bus_read('h7777, 1'b0, 1'b0, arr('h7777), "R12 array read 2");
        bus_read('h10, 1'b0, 1'b1, 16'h0000, "R11 oe high no drive");
        bus_read('h10, 1'b1, 1'b0, 16'h0000, "R11 ce high no drive");

        // R1: inhibited writes
        bus_write('h55, 16'h0098, 1'b0, 1'b0);
        bus_read('h10, 1'b0, 1'b0, arr('h10), "R1 oe low inhibits");
        bus_write('h55, 16'h0098, 1'b1, 1'b1);
        bus_read('h10, 1'b0, 1'b0, arr('h10), "R1 ce high inhibits");

        // R10 autoselect
        bus_write('h555, 16'h0090, 1'b0, 1'b1);
        bus_read('h0, 1'b0, 1'b0, 16'h0001, "R10 manufacturer code");
        bus_read('h1, 1'b0, 1'b0, 16'h227E, "R10 device code");
        bus_read('h2, 1'b0, 1'b0, 16'h0000, "R10 other address");

        // R4 query from autoselect, R6 table, R7 unlisted
        bus_write('h55, 16'h0098, 1'b0, 1'b1);
        bus_read('h10, 1'b0, 1'b0, 16'h0051, "R4 R6 addr 10h");
        bus_read('h11, 1'b0, 1'b0, 16'h0052, "R6 addr 11h");
        bus_read('h12, 1'b0, 1'b0, 16'h0059, "R6 addr 12h");
        bus_read('h13, 1'b0, 1'b0, 16'h0002, "R6 addr 13h");
        bus_read('h14, 1'b0, 1'b0, 16'h0000, "R6 addr 14h");
        bus_read('h15, 1'b0, 1'b0, 16'h0040, "R6 addr 15h");
        bus_read('h16, 1'b0, 1'b0, 16'h0000, "R6 addr 16h");
        for (int a = 'h17; a <= 'h1A; a++)
            bus_read(AW'(a), 1'b0, 1'b0, 16'h0000, "R6 addr 17h-1Ah");
        bus_read('h30, 1'b0, 1'b0, 16'h0000, "R7 unlisted addr");
        bus_read('h0, 1'b0, 1'b0, 16'h0000, "R7 unlisted addr 0");

        // R5 query ignores autoselect entry, exits on reset command
        bus_write('h555, 16'h0090, 1'b0, 1'b1);
        bus_read('h10, 1'b0, 1'b0, 16'h0051, "R5 autoselect ignored in query");
        bus_write('h1234, 16'h00F0, 1'b0, 1'b1);
        bus_read('h10, 1'b0, 1'b0, arr('h10), "R5 reset returns to read");

        // R2: address changes within low phase; last one used
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 'h100; dq_in = 16'h0098;
        idle(3);
        addr = 'h55;
        idle(3);
        we_n = 1'b1;
        idle(2);
        ce_n = 1'b1;
        idle(3);
        bus_read('h11, 1'b0, 1'b0, 16'h0052, "R2 R3 query from read, last address");
        bus_write('h0, 16'h00F0, 1'b0, 1'b1);

        // R8 lockout
        bus_write('h55, 16'h0098, 1'b0, 1'b1);
        bus_read('h12, 1'b0, 1'b0, 16'h0059, "R3 query entry");
        @(negedge clk); lockout = 1'b1; idle(3);
        bus_read('h12, 1'b0, 1'b0, arr('h12), "R8 lockout clears mode");
        bus_write('h55, 16'h0098, 1'b0, 1'b1);
        bus_read('h12, 1'b0, 1'b0, arr('h12), "R8 write ignored in lockout");
        @(negedge clk); lockout = 1'b0; idle(3);
        bus_read('h12, 1'b0, 1'b0, arr('h12), "R8 still read after release");
        bus_write('h55, 16'h0098, 1'b0, 1'b1);
        bus_read('h12, 1'b0, 1'b0, 16'h0059, "R8 writes accepted after release");

        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule